// File: doc/BRIEF.md
# Buffer-Linked DMA Request Channels

This block is a bank of programmable DMA request channels that sits beside the buffer RAM of a multi-buffered serial peripheral. Each channel is tied to one buffer index. When the sequencer reports that this buffer has finished a transmit or a receive, the channel raises a request toward the system DMA engine. The transmit request and the receive request each go out on a request line chosen by the channel's configuration. Moving the data is the DMA engine's job, and the RAM data path lies outside this block.

Each channel counts a block of `ICOUNT+1` requests. A live counter moves down by one for every buffer completion that the channel serves. When the block is finished, the counter reloads, and in one-shot mode the channel also switches off its own enables. A large-count mode takes the initial count from a wide per-channel count register instead of the short field in the control word. Several channels can watch different buffers of the same transfer group, and each one fires on its own buffer.

Each channel runs a small state machine. `CH_OFF` means neither enable is set. `CH_RUN` means the channel is enabled and more than one request is left in the block. `CH_LAST` means the next request closes the block. The transitions are:
- enable-rise: `CH_OFF` goes to `CH_RUN`, or to `CH_LAST` when the initial count is zero.
- count-down: `CH_RUN` goes to `CH_LAST` when the count reaches zero.
- block-wrap: `CH_LAST` goes to `CH_RUN` or `CH_LAST` when one-shot mode is off.
- self-disable: `CH_LAST` goes to `CH_OFF` in one-shot mode.
- write-disable: any state goes to `CH_OFF` when a write clears both enables.

Top module: `dreq_bank`

## Requirements
- R1: After reset, `req_line` is 0. Every control word, count word and the mode word reads back as 0.
- R2: The control word of channel c sits at address c and reads back as follows: bit 31 is one-shot, [30:24] is the buffer index, [23:20] is the RX line, [19:16] is the TX line, bit 15 is the RX enable, bit 14 is the TX enable, [13:8] is ICOUNT[5:0], and [7:0] is 0.
- R3: A TX completion whose buffer index matches an enabled TX channel puts a pulse exactly one cycle long on that channel's TX line. The pulse appears in the cycle after the event.
- R4: RX completions are handled the same way on the RX line, independently of TX. A channel with only its TX enable set ignores RX events, and the reverse holds too.
- R5: A completion event has no effect when its index matches no enabled channel. It raises no request and leaves COUNT unchanged.
- R6: The count word of channel c sits at address 8+c and reads as ICOUNT[31:16] and COUNT[15:0]. When an enable bit is set, COUNT is loaded from ICOUNT. COUNT drops by one in every cycle in which the channel issues a request.
- R7: The request issued while COUNT is 0 ends the block and reloads COUNT from ICOUNT. In one-shot mode it also clears both enables, so later events are ignored.
- R8: Bit 0 of the mode word at address 16 selects large-count mode. In that mode a control write leaves ICOUNT unchanged, and ICOUNT comes from a count-word write, which must come before the enable. In normal mode a control write loads ICOUNT from [13:8].
- R9: Channels bound to different buffers, or to the same buffer, each fire on their own match. Requests from several channels that map to the same line in one cycle are ORed onto that line.
- R10: A TX and an RX completion for the same channel in the same cycle issue both requests, and COUNT drops by only one.
- R11: A control write to a channel in the same cycle as a matching event still issues the request. The written fields take effect, and COUNT and state are not advanced by the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tx_done | input | 1 | A buffer finished transmitting |
| tx_buf | input | 7 | Index of that buffer |
| rx_done | input | 1 | A buffer finished receiving |
| rx_buf | input | 7 | Index of that buffer |
| req_line | output | 16 | Registered DMA request pulses |

## Verification
An event presented before a rising edge produces its request pulse on `req_line` right after that same edge. COUNT, the enables and the state also change at that edge. Register writes take effect at the edge that samples them. Because `rd_data` is combinational, every result is visible one edge after its stimulus. The bench drives inputs on the falling edge and samples `req_line` on the next falling edge. It reads the count and control words a moment after a falling edge, so each check falls in the half-cycle after the edge that made the change.

// File: rtl/dreq_pkg.sv
`timescale 1ns/1ps
package dreq_pkg;
    parameter int unsigned NUM_CH       = 8;
    parameter int unsigned NUM_LINES    = 16;
    parameter int unsigned NUM_BUF      = 128;
    parameter int unsigned CNT_W        = 16;
    parameter int unsigned ICNT_SMALL_W = 6;

    localparam int unsigned LINE_W    = $clog2(NUM_LINES);
    localparam int unsigned BUF_W     = $clog2(NUM_BUF);
    localparam int unsigned ADDR_W    = $clog2(2 * NUM_CH + 1);
    localparam int unsigned MODE_IDX  = 2 * NUM_CH;

    // control word layout
    localparam int unsigned OS_BIT    = 31;
    localparam int unsigned BUF_LSB   = 24;
    localparam int unsigned RXMAP_LSB = 20;
    localparam int unsigned TXMAP_LSB = 16;
    localparam int unsigned RXEN_BIT  = 15;
    localparam int unsigned TXEN_BIT  = 14;
    localparam int unsigned ICNT_LSB  = 8;
    // count word layout
    localparam int unsigned IC_LSB    = 16;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RUN  = 2'd1,
        CH_LAST = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic              oneshot;
        logic [BUF_W-1:0]  bufid;
        logic [LINE_W-1:0] rx_map;
        logic [LINE_W-1:0] tx_map;
        logic              rx_en;
        logic              tx_en;
    } ch_cfg_t;
endpackage

// File: rtl/dreq_channel.sv
`timescale 1ns/1ps
module dreq_channel
    import dreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcm_i,
    input  logic              ctrl_we_i,
    input  logic              cnt_we_i,
    input  logic [31:0]       wdata_i,
    input  logic              tx_done_i,
    input  logic [BUF_W-1:0]  tx_buf_i,
    input  logic              rx_done_i,
    input  logic [BUF_W-1:0]  rx_buf_i,
    output logic              tx_fire_o,
    output logic              rx_fire_o,
    output logic [LINE_W-1:0] tx_map_o,
    output logic [LINE_W-1:0] rx_map_o,
    output logic              on_o,
    output logic [31:0]       ctrl_rd_o,
    output logic [31:0]       cnt_rd_o
);
    ch_cfg_t          cfg_q, cfg_d, cfg_w;
    logic [CNT_W-1:0] icnt_q, icnt_d, icnt_w;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    ch_state_e        st_q, st_d;
    logic             hit, rise;
    logic             unused_low;

    assign unused_low = ^wdata_i[ICNT_LSB-1:0];

    // decoded view of an incoming control write
    always_comb begin
        cfg_w.oneshot = wdata_i[OS_BIT];
        cfg_w.bufid   = wdata_i[BUF_LSB +: BUF_W];
        cfg_w.rx_map  = wdata_i[RXMAP_LSB +: LINE_W];
        cfg_w.tx_map  = wdata_i[TXMAP_LSB +: LINE_W];
        cfg_w.rx_en   = wdata_i[RXEN_BIT];
        cfg_w.tx_en   = wdata_i[TXEN_BIT];
        icnt_w        = lcm_i ? icnt_q : CNT_W'(wdata_i[ICNT_LSB +: ICNT_SMALL_W]);
        rise          = (cfg_w.tx_en & ~cfg_q.tx_en) | (cfg_w.rx_en & ~cfg_q.rx_en);
    end

    // output process: request strobes and readback
    always_comb begin
        tx_fire_o = cfg_q.tx_en && tx_done_i && (tx_buf_i == cfg_q.bufid);
        rx_fire_o = cfg_q.rx_en && rx_done_i && (rx_buf_i == cfg_q.bufid);
        hit       = tx_fire_o | rx_fire_o;
        tx_map_o  = cfg_q.tx_map;
        rx_map_o  = cfg_q.rx_map;
        on_o      = (st_q != CH_OFF);
        ctrl_rd_o = '0;
        ctrl_rd_o[OS_BIT]                    = cfg_q.oneshot;
        ctrl_rd_o[BUF_LSB +: BUF_W]          = cfg_q.bufid;
        ctrl_rd_o[RXMAP_LSB +: LINE_W]       = cfg_q.rx_map;
        ctrl_rd_o[TXMAP_LSB +: LINE_W]       = cfg_q.tx_map;
        ctrl_rd_o[RXEN_BIT]                  = cfg_q.rx_en;
        ctrl_rd_o[TXEN_BIT]                  = cfg_q.tx_en;
        ctrl_rd_o[ICNT_LSB +: ICNT_SMALL_W]  = icnt_q[ICNT_SMALL_W-1:0];
        cnt_rd_o = '0;
        cnt_rd_o[IC_LSB +: CNT_W]            = icnt_q;
        cnt_rd_o[0 +: CNT_W]                 = cnt_q;
    end

    // next-state process
    always_comb begin
        cfg_d  = cfg_q;
        icnt_d = icnt_q;
        cnt_d  = cnt_q;
        st_d   = st_q;
        if (cnt_we_i) begin
            icnt_d = wdata_i[IC_LSB +: CNT_W];
        end
        if (ctrl_we_i) begin
            cfg_d  = cfg_w;
            icnt_d = icnt_w;
            unique case (st_q)
                CH_OFF: begin
                    if (rise) begin
                        cnt_d = icnt_w;
                        st_d  = (icnt_w == '0) ? CH_LAST : CH_RUN;
                    end
                end
                CH_RUN, CH_LAST: begin
                    if (!cfg_w.tx_en && !cfg_w.rx_en) begin
                        st_d = CH_OFF;
                    end else if (rise) begin
                        cnt_d = icnt_w;
                        st_d  = (icnt_w == '0) ? CH_LAST : CH_RUN;
                    end
                end
                default: st_d = CH_OFF;
            endcase
        end else if (hit) begin
            unique case (st_q)
                CH_RUN: begin
                    cnt_d = cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) st_d = CH_LAST;
                end
                CH_LAST: begin
                    cnt_d = icnt_q;
                    if (cfg_q.oneshot) begin
                        cfg_d.tx_en = 1'b0;
                        cfg_d.rx_en = 1'b0;
                        st_d        = CH_OFF;
                    end else begin
                        st_d = (icnt_q == '0) ? CH_LAST : CH_RUN;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            icnt_q <= '0;
            cnt_q  <= '0;
            st_q   <= CH_OFF;
        end else begin
            cfg_q  <= cfg_d;
            icnt_q <= icnt_d;
            cnt_q  <= cnt_d;
            st_q   <= st_d;
        end
    end
endmodule

// File: rtl/dreq_router.sv
`timescale 1ns/1ps
module dreq_router
    import dreq_pkg::*;
(
    input  logic [NUM_CH-1:0] tx_fire_i,
    input  logic [NUM_CH-1:0] rx_fire_i,
    input  logic [LINE_W-1:0] tx_map_i [NUM_CH],
    input  logic [LINE_W-1:0] rx_map_i [NUM_CH],
    output logic [NUM_LINES-1:0] lines_o
);
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        always_comb begin
            lines_o[l] = 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (tx_fire_i[c] && tx_map_i[c] == LINE_W'(l)) lines_o[l] = 1'b1;
                if (rx_fire_i[c] && rx_map_i[c] == LINE_W'(l)) lines_o[l] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dreq_bank.sv
`timescale 1ns/1ps
module dreq_bank
    import dreq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [31:0]          rd_data,
    input  logic                 tx_done,
    input  logic [BUF_W-1:0]     tx_buf,
    input  logic                 rx_done,
    input  logic [BUF_W-1:0]     rx_buf,
    output logic [NUM_LINES-1:0] req_line
);
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_IDX);

    logic                  lcm_q;
    logic [NUM_CH-1:0]     tx_fire, rx_fire, chan_on;
    logic [LINE_W-1:0]     tx_map [NUM_CH];
    logic [LINE_W-1:0]     rx_map [NUM_CH];
    logic [31:0]           ctrl_rd [NUM_CH];
    logic [31:0]           cnt_rd  [NUM_CH];
    logic [NUM_LINES-1:0]  lines_d;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dreq_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .lcm_i     (lcm_q),
            .ctrl_we_i (wr_en && wr_addr == ADDR_W'(c)),
            .cnt_we_i  (wr_en && wr_addr == ADDR_W'(NUM_CH + c)),
            .wdata_i   (wr_data),
            .tx_done_i (tx_done),
            .tx_buf_i  (tx_buf),
            .rx_done_i (rx_done),
            .rx_buf_i  (rx_buf),
            .tx_fire_o (tx_fire[c]),
            .rx_fire_o (rx_fire[c]),
            .tx_map_o  (tx_map[c]),
            .rx_map_o  (rx_map[c]),
            .on_o      (chan_on[c]),
            .ctrl_rd_o (ctrl_rd[c]),
            .cnt_rd_o  (cnt_rd[c])
        );
    end

    dreq_router u_router (
        .tx_fire_i (tx_fire),
        .rx_fire_i (rx_fire),
        .tx_map_i  (tx_map),
        .rx_map_i  (rx_map),
        .lines_o   (lines_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcm_q    <= 1'b0;
            req_line <= '0;
        end else begin
            req_line <= lines_d;
            if (wr_en && wr_addr == MODE_ADDR) lcm_q <= wr_data[0];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(c))          rd_data = ctrl_rd[c];
            if (rd_addr == ADDR_W'(NUM_CH + c)) rd_data = cnt_rd[c];
        end
        if (rd_addr == MODE_ADDR) rd_data = 32'(lcm_q);
    end
endmodule

// File: rtl/dreq_bank_chk.sv
`timescale 1ns/1ps
module dreq_bank_chk
    import dreq_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic                 wr_bit0,
    input logic [ADDR_W-1:0]    rd_addr,
    input logic [31:0]          rd_data,
    input logic                 tx_done,
    input logic                 rx_done,
    input logic [NUM_LINES-1:0] req_line,
    input logic [NUM_CH-1:0]    chan_on
);
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_IDX);

    // R3
    req_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_done && !rx_done) |=> (req_line == '0));

    // R5
    req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_line) |-> $past(|chan_on));

    // R8
    mode_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == MODE_ADDR && rd_addr == MODE_ADDR)
        |=> ($stable(rd_addr) -> (rd_data[0] == $past(wr_bit0))));

    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !tx_done && !rx_done) |=> ($stable(rd_addr) -> $stable(rd_data)));
endmodule

bind dreq_bank dreq_bank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_bit0  (wr_data[0]),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .tx_done  (tx_done),
    .rx_done  (rx_done),
    .req_line (req_line),
    .chan_on  (chan_on)
);

// File: tb/sim_dreq_bank.sv
`timescale 1ns/1ps
module sim_dreq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tx_done = 1'b0;
    logic [6:0]  tx_buf = '0;
    logic        rx_done = 1'b0;
    logic [6:0]  rx_buf = '0;
    logic [15:0] req_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dreq_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tx_done(tx_done), .tx_buf(tx_buf),
        .rx_done(rx_done), .rx_buf(rx_buf), .req_line(req_line)
    );

    typedef struct packed {
        logic        txd;
        logic [6:0]  txb;
        logic        rxd;
        logic [6:0]  rxb;
        logic [15:0] exp;
    } vec_t;

    // channels: 0 buf3 tx->2 rx->5, 1 buf4 rx->5, 2 buf3 tx->9
    localparam vec_t VECS [8] = '{
        '{1'b1, 7'd3, 1'b0, 7'd0, 16'h0204},
        '{1'b0, 7'd0, 1'b1, 7'd3, 16'h0020},
        '{1'b0, 7'd0, 1'b1, 7'd4, 16'h0020},
        '{1'b1, 7'd4, 1'b1, 7'd3, 16'h0020},
        '{1'b1, 7'd7, 1'b0, 7'd0, 16'h0000},
        '{1'b1, 7'd3, 1'b1, 7'd4, 16'h0224},
        '{1'b0, 7'd0, 1'b0, 7'd0, 16'h0000},
        '{1'b1, 7'd3, 1'b1, 7'd3, 16'h0224}
    };

    function automatic logic [31:0] mk(bit os, int b, int rxm, int txm, bit rxe, bit txe, int ic);
        return {os, 7'(b), 4'(rxm), 4'(txm), rxe, txe, 6'(ic), 8'h00};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        rd_addr = 5'(a);
        #1;
        v = rd_data;
    endtask

    task automatic ev(logic txd, int txb, logic rxd, int rxb, logic [15:0] exp, string tag);
        @(negedge clk);
        tx_done = txd; tx_buf = 7'(txb); rx_done = rxd; rx_buf = 7'(rxb);
        @(negedge clk);
        chk(tag, 32'(req_line), 32'(exp));
        tx_done = 1'b0; rx_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req_line", 32'(req_line), 32'h0);
        rd(0, v);  chk("R1 ctrl0", v, 32'h0);
        rd(15, v); chk("R1 count7", v, 32'h0);
        rd(16, v); chk("R1 mode", v, 32'h0);

        // table setup
        wr(0, mk(0, 3, 5, 2, 1, 1, 63));
        wr(1, mk(0, 4, 5, 0, 1, 0, 63));
        wr(2, mk(0, 3, 0, 9, 0, 1, 63));
        rd(0, v); chk("R2 ctrl0 readback", v, mk(0, 3, 5, 2, 1, 1, 63));
        rd(8, v); chk("R6 count0 after enable", v, 32'h003F_003F);

        // R3 R4 R5 R9 R10 table walk
        for (int i = 0; i < 8; i++) begin
            ev(VECS[i].txd, int'(VECS[i].txb), VECS[i].rxd, int'(VECS[i].rxb),
               VECS[i].exp, $sformatf("R3/R4/R9 vector %0d", i));
        end
        // R6 R10: ch0 served 5 cycles, ch1 2, ch2 3
        rd(8, v);  chk("R10 count0", v, 32'h003F_003A);
        rd(9, v);  chk("R6 count1", v, 32'h003F_003D);
        rd(10, v); chk("R6 count2", v, 32'h003F_003C);

        // R7 one-shot block of 3 on ch3
        wr(3, mk(1, 10, 15, 0, 1, 0, 2));
        ev(0, 0, 1, 10, 16'h8000, "R7 oneshot req1");
        ev(0, 0, 1, 10, 16'h8000, "R7 oneshot req2");
        rd(11, v); chk("R7 oneshot count at last", v, 32'h0002_0000);
        ev(0, 0, 1, 10, 16'h8000, "R7 oneshot req3");
        rd(3, v);  chk("R7 oneshot enables cleared", v, mk(1, 10, 15, 0, 0, 0, 2));
        rd(11, v); chk("R7 oneshot count reloaded", v, 32'h0002_0002);
        ev(0, 0, 1, 10, 16'h0000, "R5 disabled channel no req");
        rd(11, v); chk("R5 disabled count held", v, 32'h0002_0002);

        // R7 wrap without one-shot on ch4
        wr(4, mk(0, 11, 0, 0, 0, 1, 1));
        ev(1, 11, 0, 0, 16'h0001, "R7 wrap req1");
        ev(1, 11, 0, 0, 16'h0001, "R7 wrap req2");
        rd(12, v); chk("R7 wrap reloaded", v, 32'h0001_0001);
        ev(1, 11, 0, 0, 16'h0001, "R7 wrap req3");
        rd(12, v); chk("R7 wrap count", v, 32'h0001_0000);

        // R11 write and event in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd4; wr_data = mk(0, 11, 0, 0, 0, 0, 1);
        tx_done = 1'b1; tx_buf = 7'd11;
        @(negedge clk);
        chk("R11 collision req", 32'(req_line), 32'h0001);
        wr_en = 1'b0; tx_done = 1'b0;
        rd(4, v);  chk("R11 written ctrl", v, mk(0, 11, 0, 0, 0, 0, 1));
        rd(12, v); chk("R11 count not advanced", v, 32'h0001_0000);

        // R8 large-count mode
        wr(16, 32'h1);
        rd(16, v); chk("R8 mode set", v, 32'h1);
        wr(13, 32'(300) << 16);
        wr(5, mk(0, 20, 0, 7, 0, 1, 5));
        rd(13, v); chk("R8 icount from count word", v, 32'h012C_012C);
        ev(1, 20, 0, 0, 16'h0080, "R8 large-count req");
        rd(13, v); chk("R8 count decremented", v, 32'h012C_012B);
        wr(5, mk(0, 20, 0, 7, 0, 1, 9));
        rd(13, v); chk("R8 ctrl write keeps icount", v, 32'h012C_012B);
        wr(16, 32'h0);
        wr(6, mk(0, 21, 0, 0, 0, 1, 5));
        rd(14, v); chk("R8 normal mode icount from ctrl", v, 32'h0005_0005);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule